// File: doc/BRIEF.md
# Backplane Slot Scan Sequencer

This block walks through the module slots of one backplane unit during power-up configuration, pulling exactly one active-low slot select low at a time. The host controller opens a pass with an active-low start pulse. The rising clock edge that sees the pulse low selects the first slot. Each later edge moves the select one slot onward. The edge after the last slot has been selected releases every select and sets a local done flag.

The host runs the same pass twice: once while it reads each module's identity word, and once while it writes each module's assigned address. Units are cascaded. Each unit ANDs its local done flag with the done signal coming from the next unit, and drives the result toward the previous unit or the host. The host therefore sees completion only after every slot of every unit has been visited. In the last unit of a chain, the cascade input is tied high. Bus buffering and the read and write cycles are handled elsewhere.

Top module: `slot_scan_top`

## Requirements
- R1: While reset is asserted, and after it is released, all slot selects are high and the cascade output is low until a pass completes.
- R2: At a rising edge where the start input is low, slot 0 becomes selected (its select goes low) and the local done flag is cleared. Both changes appear right after that edge.
- R3: With start high, each rising edge moves the select from slot k to slot k+1, in ascending index order.
- R4: At most one slot select is low at any time.
- R5: The edge after the highest-numbered slot has been selected drives all selects high and sets the local done flag. With a single slot, this is the second edge after start.
- R6: The local done flag stays set until the next start is captured. While idle, the selects stay high.
- R7: The cascade output equals local done AND the cascade input. It follows the cascade input without waiting for a clock edge.
- R8: A start captured while a pass is in progress restarts the pass at slot 0.
- R9: While start is held low across several edges, slot 0 stays selected. The pass advances only from the first edge at which start is high.
- R10: A second pass started after completion produces the same slot sequence and done timing as the first pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startN | input | 1 | Active-low start request from the host |
| chainDoneIn | input | 1 | Done signal from the next unit (tie high in the last unit) |
| slotSelN | output | NUM_SLOTS | Active-low one-hot slot selects; bit 0 is the first slot |
| chainDoneOut | output | 1 | Local done AND chainDoneIn, driven toward the host |

## Verification
The bench builds two copies of the block and drives both with the same inputs. One copy uses the default of four slots. The other uses a single slot, where the first slot is also the last: this makes the start edge and the finish edge adjacent and exercises the case where load and finish compete. Both copies are compared every clock against a behavioural position-and-flag model. The stimulus covers restarts in mid-pass, a start held low for several edges, and toggling of the cascade input while the block is idle and while a pass is running.

// File: rtl/slot_scan_pkg.sv
package slot_scan_pkg;
  typedef struct packed {
    logic load;     // begin a pass at slot 0 and clear done
    logic advance;  // shift selection to the next slot
    logic finish;   // release all selects and set done
  } scanStrobes_t;
endpackage

// File: rtl/slot_scan_ctrl.sv
module slot_scan_ctrl
  import slot_scan_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startN,
  input  logic         busy,
  input  logic         lastHit,
  output scanStrobes_t strobes
);
  always_comb begin
    strobes.load    = ~startN;
    strobes.advance = startN & busy & ~lastHit;
    strobes.finish  = startN & lastHit;
  end

  // R2 R3 R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.load, strobes.advance, strobes.finish}));
endmodule

// File: rtl/slot_scan_path.sv
module slot_scan_path
  import slot_scan_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  scanStrobes_t         strobes,
  output logic [NUM_SLOTS-1:0] selOneHot,
  output logic                 busy,
  output logic                 lastHit,
  output logic                 localDone
);
  localparam int LAST_IDX = NUM_SLOTS - 1;

  logic [NUM_SLOTS-1:0] selNext;

  always_comb begin
    selNext = selOneHot;
    if (strobes.load)         selNext = NUM_SLOTS'(1);
    else if (strobes.finish)  selNext = '0;
    else if (strobes.advance) selNext = selOneHot << 1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selOneHot <= '0;
      localDone <= 1'b0;
    end else begin
      selOneHot <= selNext;
      if (strobes.load)        localDone <= 1'b0;
      else if (strobes.finish) localDone <= 1'b1;
    end
  end

  assign busy    = |selOneHot;
  assign lastHit = selOneHot[LAST_IDX];

  // R4
  one_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(selOneHot));

  // R2
  load_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (selOneHot == NUM_SLOTS'(1)) && !localDone);

  // R5
  finish_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lastHit && !strobes.load) |=> (selOneHot == '0) && localDone);

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (localDone && !strobes.load) |=> localDone);

  // R3
  step_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastHit && !strobes.load) |=> (selOneHot == ($past(selOneHot) << 1)));
endmodule

// File: rtl/slot_scan_top.sv
module slot_scan_top
  import slot_scan_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startN,
  input  logic                 chainDoneIn,
  output logic [NUM_SLOTS-1:0] slotSelN,
  output logic                 chainDoneOut
);
  scanStrobes_t         strobes;
  logic [NUM_SLOTS-1:0] selOneHot;
  logic                 busy;
  logic                 lastHit;
  logic                 localDone;

  slot_scan_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .startN(startN),
    .busy(busy), .lastHit(lastHit), .strobes(strobes)
  );

  slot_scan_path #(.NUM_SLOTS(NUM_SLOTS)) i_path (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .selOneHot(selOneHot), .busy(busy), .lastHit(lastHit), .localDone(localDone)
  );

  assign slotSelN     = ~selOneHot;
  assign chainDoneOut = localDone & chainDoneIn;

  // R7
  chain_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    chainDoneOut |-> (chainDoneIn && (&slotSelN)));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |-> (&slotSelN) && !chainDoneOut);
endmodule

// File: tb/test_slot_scan_top.sv
module test_slot_scan_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startN = 1'b1;
  logic chainDoneIn = 1'b1;
  logic [3:0] selA;
  logic [0:0] selB;
  logic doneA, doneB;

  int checks = 0;
  int fails = 0;
  string curReq = "R1";
  int posM[2];
  bit doneM[2];
  int nSl[2];
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  slot_scan_top #(.NUM_SLOTS(4)) i_slot_scan_top (
    .clk(clk), .rstN(rstN), .startN(startN), .chainDoneIn(chainDoneIn),
    .slotSelN(selA), .chainDoneOut(doneA));

  slot_scan_top #(.NUM_SLOTS(1)) i_slot_scan_top_one (
    .clk(clk), .rstN(rstN), .startN(startN), .chainDoneIn(chainDoneIn),
    .slotSelN(selB), .chainDoneOut(doneB));

  task automatic modelEdge();
    for (int u = 0; u < 2; u++) begin
      if (!rstN) begin posM[u] = -1; doneM[u] = 1'b0; end
      else if (!startN) begin posM[u] = 0; doneM[u] = 1'b0; end
      else if (posM[u] >= 0) begin
        if (posM[u] == nSl[u] - 1) begin posM[u] = -1; doneM[u] = 1'b1; end
        else posM[u] = posM[u] + 1;
      end
    end
  endtask

  task automatic compare();
    for (int u = 0; u < 2; u++) begin
      int expSel;
      int actSel;
      bit expDone;
      bit actDone;
      expSel = (1 << nSl[u]) - 1;
      if (posM[u] >= 0) expSel = expSel & ~(1 << posM[u]);
      expDone = doneM[u] & chainDoneIn;
      actSel = (u == 0) ? int'(selA) : int'(selB);
      actDone = (u == 0) ? doneA : doneB;
      checks++;
      if (actSel != expSel || actDone != expDone) begin
        fails++;
        $display("FAIL %s unit%0d sel=%0h done=%0b expected sel=%0h done=%0b",
                 curReq, u, actSel, actDone, expSel, expDone);
      end
    end
  endtask

  task automatic step();
    modelEdge();
    @(posedge clk);
    #1;
    compare();
  endtask

  task automatic drive(input logic s, input logic c, input int n);
    startN = s;
    chainDoneIn = c;
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired in %s actual=hung expected=finish", curReq);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    nSl[0] = 4; nSl[1] = 1;
    posM[0] = -1; posM[1] = -1; doneM[0] = 0; doneM[1] = 0;
    curReq = "R1"; drive(1, 1, 3);
    rstN = 1'b1;
    drive(1, 1, 2);
    curReq = "R2"; drive(0, 1, 1);
    curReq = "R3"; drive(1, 1, 3);
    curReq = "R5"; drive(1, 1, 1);
    curReq = "R6"; drive(1, 1, 3);
    curReq = "R7"; drive(1, 0, 2); drive(1, 1, 1);
    curReq = "R10"; drive(0, 1, 1); drive(1, 1, 1); drive(1, 0, 2); drive(1, 1, 4);
    curReq = "R8"; drive(0, 1, 1); drive(1, 1, 2); drive(0, 1, 1); drive(1, 1, 6);
    curReq = "R9"; drive(0, 1, 3); drive(1, 1, 6);
    curReq = "R4"; drive(0, 0, 1); drive(1, 0, 5);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule